// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block models the control side of a 16-bit DRAM that has two column strobes, one for each byte. The row strobe, both column strobes, the write-enable and the output-enable are all active low. They are sampled on a fast system clock. The block works out the kind of each memory cycle only from the order in which the strobe edges arrive. It then runs that cycle against a small internal array that is split into two byte lanes. The array is addressed by a multiplexed address bus: the row is taken when the row strobe falls, and the column is taken when the earlier column strobe falls.

Each byte lane has its own drive enable, and read data leaves on a 16-bit bus. The lower lane is controlled by the lower column strobe and the upper lane by the upper column strobe. A column strobe that is already low when the row strobe falls starts a refresh cycle. That refresh uses an internal row pointer, which moves on by one when the cycle ends. If the refresh follows a read and the column strobes are held low through it, the read data stays on the bus for the whole refresh. The decoded cycle state, the refresh pointer and a flag for a badly formed refresh cycle are all brought out to ports.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, and whenever the row strobe is high with no read data held, `state_o` is 0 (standby) and `dq_oe_o` is 00. Nothing in this state writes the array.
- R2: When the row strobe falls with both column strobes high, the row is latched from the low ROW_W bits of `addr_i`. Until a column strobe falls, `state_o` is 1 and no lane is driven.
- R3: With the row strobe low, a column strobe low, write-enable high and output-enable low, `state_o` is 2. Bit 0 of `dq_oe_o` follows the lower strobe and drives `dq_o[7:0]`. Bit 1 follows the upper strobe and drives `dq_o[15:8]`. The data comes from the latched row and column and appears one clock after the sampled inputs.
- R4: With write-enable low, `state_o` is 3. On any column strobe falling edge, each lane whose strobe is low is written with the matching byte of `dq_i`. A lane whose strobe is high keeps its old byte. No lane is driven.
- R5: With a column strobe low and both write-enable and output-enable high, `state_o` is 4 and no lane is driven.
- R6: A column strobe that is low when the row strobe falls gives a refresh cycle with `state_o` 5. Such a cycle does not write the array and does not use `addr_i`. `rfsh_row_o` goes up by one in the clock after the row strobe rises.
- R7: The column is latched on the first column strobe fall after both column strobes were high. With skewed strobes, the later fall writes every low lane from the `dq_i` present at that edge, at the first column.
- R8: `rfsh_row_o` resets to 0 and wraps from 2**ROW_W-1 back to 0.
- R9: If write-enable is low when a refresh cycle's row strobe falls, `cbr_err_o` is 1. Otherwise it is 0. The flag keeps its value until the next row strobe fall.
- R10: Suppose the row strobe rises after a read while a column strobe stays low. Then `state_o` is 6 and the lanes that were driven keep their enables and data. A following row strobe fall gives `state_o` 7, a refresh, with the same data still driven.
- R11: Within one row cycle, raising both column strobes and lowering one again latches a new column and reads or writes at that column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| ucas_n_i | input | 1 | Upper byte column strobe, active low |
| lcas_n_i | input | 1 | Lower byte column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | 16 | Write data |
| dq_o | output | 16 | Read data |
| dq_oe_o | output | 2 | Lane drive enables, bit 0 lower, bit 1 upper |
| state_o | output | 3 | Decoded cycle state |
| rfsh_row_o | output | ROW_W | Internal refresh row pointer |
| cbr_err_o | output | 1 | Refresh cycle started with write-enable low |

## Verification
A wrong latched row or column shows up on `dq_o` in the first read that follows. This is one clock after that read's strobe edge, because the sweep writes a distinct word to every location and then reads every location back. A wrong cycle classification is visible on `state_o` and `dq_oe_o` in the clock after the edge that caused it. A refresh pointer that slips or fails to wrap shows on `rfsh_row_o` one clock after the row strobe rises, and the counting sequence runs past a wrap. A write that leaks into the wrong lane, or a write made during a refresh, is caught by the read-back of the bytes around it.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ROW    = 3'd1,
    ST_READ   = 3'd2,
    ST_WRITE  = 3'd3,
    ST_NOP    = 3'd4,
    ST_CBR    = 3'd5,
    ST_HOLD   = 3'd6,
    ST_HIDDEN = 3'd7
  } dcd_state_e;

  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/dcd_strobe_edges.sv
module dcd_strobe_edges #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_n_i,
  input  logic [LANES-1:0] cas_n_i,
  output logic             ras_fall_o,
  output logic             ras_rise_o,
  output logic [LANES-1:0] cas_fell_o,
  output logic             cas_was_idle_o
);
  logic             ras_q;
  logic [LANES-1:0] cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      cas_q <= '1;
    end else begin
      ras_q <= ras_n_i;
      cas_q <= cas_n_i;
    end
  end

  assign ras_fall_o     = ras_q & ~ras_n_i;
  assign ras_rise_o     = ~ras_q & ras_n_i;
  assign cas_was_idle_o = &cas_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cas_fell_o[l] = cas_q[l] & ~cas_n_i[l];
  end
endmodule

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
  parameter int unsigned ROW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] ptr_o
);
  logic [ROW_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_q + ROW_W'(1);
  end

  assign ptr_o = ptr_q;

  a_r6_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_o == ROW_W'($past(ptr_o) + ROW_W'(1)));
  a_r8_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && ptr_o == '1) |=> ptr_o == '0);
  a_r6_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/dcd_lane_array.sv
module dcd_lane_array #(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (be_i[l]) mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[addr_i];
  end
endmodule

// File: rtl/dcd_cycle_fsm.sv
module dcd_cycle_fsm
  import dcd_pkg::*;
#(
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned COL_W  = 3,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned AW    = ROW_W + COL_W,
  localparam int unsigned DW    = NUM_LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ras_n_i,
  input  logic [NUM_LANES-1:0] cas_n_i,
  input  logic                 we_n_i,
  input  logic                 oe_n_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 ras_fall_i,
  input  logic                 ras_rise_i,
  input  logic [NUM_LANES-1:0] cas_fell_i,
  input  logic                 cas_was_idle_i,
  input  logic [DW-1:0]        rd_data_i,
  output logic [AW-1:0]        mem_addr_o,
  output logic [NUM_LANES-1:0] wr_be_o,
  output logic                 rfsh_adv_o,
  output logic [DW-1:0]        dq_o,
  output logic [NUM_LANES-1:0] dq_oe_o,
  output logic [2:0]           state_o,
  output logic                 cbr_err_o
);
  dcd_state_e           state_q, state_d;
  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     col_q, col_eff;
  logic [DW-1:0]        dq_q, dq_d;
  logic [NUM_LANES-1:0] oe_q, oe_d;
  logic                 err_q;
  logic                 any_cas_low, in_row_cyc, in_rfsh, first_fall;

  assign any_cas_low = ~&cas_n_i;
  assign in_row_cyc  = state_q inside {ST_ROW, ST_READ, ST_WRITE, ST_NOP};
  assign in_rfsh     = state_q inside {ST_CBR, ST_HIDDEN};
  assign first_fall  = !ras_n_i && !ras_fall_i && in_row_cyc && cas_was_idle_i && any_cas_low;
  assign col_eff     = first_fall ? addr_i[COL_W-1:0] : col_q;
  assign mem_addr_o  = {row_q, col_eff};

  always_comb begin
    state_d = state_q;
    if (!ras_n_i) begin
      if (ras_fall_i)       state_d = any_cas_low ? ((state_q == ST_HOLD) ? ST_HIDDEN : ST_CBR) : ST_ROW;
      else if (in_rfsh)     state_d = state_q;
      else if (!any_cas_low) state_d = ST_ROW;
      else if (!we_n_i)     state_d = ST_WRITE;
      else if (!oe_n_i)     state_d = ST_READ;
      else                  state_d = ST_NOP;
    end else begin
      // read data survives a row strobe rise while a column strobe stays low
      if ((state_q inside {ST_READ, ST_HOLD, ST_HIDDEN}) && any_cas_low) state_d = ST_HOLD;
      else                                                                state_d = ST_IDLE;
    end
  end

  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      wr_be_o[l] = (state_d == ST_WRITE) && (|cas_fell_i) && !cas_n_i[l];
      if (state_d == ST_READ)                         oe_d[l] = !cas_n_i[l];
      else if (state_d inside {ST_HOLD, ST_HIDDEN})   oe_d[l] = oe_q[l] && !cas_n_i[l];
      else                                            oe_d[l] = 1'b0;
    end
    dq_d = (state_d == ST_READ) ? rd_data_i : dq_q;
  end

  assign rfsh_adv_o = ras_rise_i && in_rfsh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      dq_q    <= '0;
      oe_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dq_q    <= dq_d;
      oe_q    <= oe_d;
      if (ras_fall_i) begin
        err_q <= any_cas_low && !we_n_i;
        if (!any_cas_low) row_q <= addr_i[ROW_W-1:0];
      end
      if (first_fall) col_q <= addr_i[COL_W-1:0];
    end
  end

  assign state_o   = state_q;
  assign dq_o      = dq_q;
  assign dq_oe_o   = oe_q;
  assign cbr_err_o = err_q;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> dq_oe_o == '0);
  a_r2_row_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ROW |-> dq_oe_o == '0);
  a_r5_nop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_NOP |-> dq_oe_o == '0);
  a_r4_write_needs_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |wr_be_o |-> (!we_n_i && !ras_n_i && !in_rfsh));
  a_r9_err_only_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cbr_err_o) |-> (state_q inside {ST_CBR, ST_HIDDEN}));
  a_r10_hidden_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HIDDEN |-> $stable(dq_o));
  a_r6_refresh_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rfsh |-> wr_be_o == '0);
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned COL_W  = 3,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int unsigned DW     = NUM_LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              ucas_n_i,
  input  logic              lcas_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic [1:0]        dq_oe_o,
  output logic [2:0]        state_o,
  output logic [ROW_W-1:0]  rfsh_row_o,
  output logic              cbr_err_o
);
  localparam int unsigned AW = ROW_W + COL_W;

  logic [NUM_LANES-1:0] cas_n, cas_fell, wr_be;
  logic                 ras_fall, ras_rise, cas_was_idle, rfsh_adv;
  logic [AW-1:0]        mem_addr;
  logic [DW-1:0]        rd_data;

  assign cas_n = {ucas_n_i, lcas_n_i};

  dcd_strobe_edges #(.LANES(NUM_LANES)) u_edges (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ras_n_i        (ras_n_i),
    .cas_n_i        (cas_n),
    .ras_fall_o     (ras_fall),
    .ras_rise_o     (ras_rise),
    .cas_fell_o     (cas_fell),
    .cas_was_idle_o (cas_was_idle)
  );

  dcd_cycle_fsm #(
    .ROW_W (ROW_W), .COL_W (COL_W), .ADDR_W (ADDR_W), .LANE_W (LANE_W)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ras_n_i        (ras_n_i),
    .cas_n_i        (cas_n),
    .we_n_i         (we_n_i),
    .oe_n_i         (oe_n_i),
    .addr_i         (addr_i),
    .ras_fall_i     (ras_fall),
    .ras_rise_i     (ras_rise),
    .cas_fell_i     (cas_fell),
    .cas_was_idle_i (cas_was_idle),
    .rd_data_i      (rd_data),
    .mem_addr_o     (mem_addr),
    .wr_be_o        (wr_be),
    .rfsh_adv_o     (rfsh_adv),
    .dq_o           (dq_o),
    .dq_oe_o        (dq_oe_o),
    .state_o        (state_o),
    .cbr_err_o      (cbr_err_o)
  );

  dcd_refresh_ctr #(.ROW_W(ROW_W)) u_rfsh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (rfsh_adv),
    .ptr_o  (rfsh_row_o)
  );

  dcd_lane_array #(.AW(AW), .LANES(NUM_LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .addr_i  (mem_addr),
    .be_i    (wr_be),
    .wdata_i (dq_i),
    .rdata_o (rd_data)
  );
endmodule

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb_top;
  localparam int ROW_W = 3;
  localparam int COL_W = 3;
  localparam int NROW  = 1 << ROW_W;
  localparam int NCOL  = 1 << COL_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [2:0]  state;
  logic [2:0]  rfsh_row;
  logic        cbr_err;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_mem [NROW*NCOL];
  int exp_ptr = 0;

  always #5 clk = ~clk;

  dram_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_n_i(ras_n), .ucas_n_i(ucas_n), .lcas_n_i(lcas_n),
    .we_n_i(we_n), .oe_n_i(oe_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out),
    .dq_oe_o(dq_oe), .state_o(state), .rfsh_row_o(rfsh_row), .cbr_err_o(cbr_err)
  );

  function automatic logic [15:0] pat(int r, int c);
    return 16'(((r * NCOL + c) * 16'h0421) ^ 16'h5A3C);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic u, input logic l, input logic w,
                     input logic o, input int a, input logic [15:0] d);
    ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o; addr = 3'(a); dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", state, 0);
    chk("R1 reset oe", dq_oe, 0);
    chk("R8 reset ptr", rfsh_row, 0);
    chk("R9 reset err", cbr_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R11 page-mode word writes over the whole array
    for (int r = 0; r < NROW; r++) begin
      cyc(0, 1, 1, 1, 1, r, 0);
      chk("R2 row state", state, 1);
      chk("R2 row quiet", dq_oe, 0);
      for (int c = 0; c < NCOL; c++) begin
        cyc(0, 0, 0, 0, 1, c, pat(r, c));
        exp_mem[r*NCOL+c] = pat(r, c);
        chk("R4 write state", state, 3);
        chk("R4 write quiet", dq_oe, 0);
        cyc(0, 1, 1, 0, 1, c, 0);
      end
      cyc(1, 1, 1, 1, 1, 0, 0);
      chk("R1 standby", state, 0);
    end

    // R1 standby ignores strobes with RAS high: no write, no drive
    cyc(1, 0, 0, 0, 0, 2, 16'hDEAD);
    chk("R1 standby oe", dq_oe, 0);
    chk("R1 standby state", state, 0);
    cyc(1, 1, 1, 1, 1, 0, 0);

    // R7 skewed word write: column from first fall, data from later fall
    cyc(0, 1, 1, 1, 1, 5, 0);
    cyc(0, 1, 0, 0, 1, 2, 16'h1111);
    cyc(0, 0, 0, 0, 1, 6, 16'h2222);
    exp_mem[5*NCOL+2] = 16'h2222;
    cyc(0, 1, 1, 1, 1, 0, 0);
    // R4 byte writes at row 5 col 4, R11 new column in the same row
    cyc(0, 1, 0, 0, 1, 4, 16'hBEEF);
    exp_mem[5*NCOL+4][7:0] = 8'hEF;
    cyc(0, 1, 1, 0, 1, 4, 0);
    cyc(0, 0, 1, 0, 1, 4, 16'h7733);
    exp_mem[5*NCOL+4][15:8] = 8'h77;
    cyc(0, 1, 1, 0, 1, 4, 0);
    // R3 byte reads
    cyc(0, 1, 0, 1, 0, 4, 0);
    chk("R3 lower read state", state, 2);
    chk("R3 lower read oe", dq_oe, 2'b01);
    chk("R4 lower byte", dq_out[7:0], exp_mem[5*NCOL+4][7:0]);
    cyc(0, 1, 1, 1, 0, 4, 0);
    cyc(0, 0, 1, 1, 0, 4, 0);
    chk("R3 upper read oe", dq_oe, 2'b10);
    chk("R4 upper byte", dq_out[15:8], exp_mem[5*NCOL+4][15:8]);
    cyc(0, 1, 1, 1, 0, 4, 0);
    // R5 no-drive cycle
    cyc(0, 0, 0, 1, 1, 4, 0);
    chk("R5 nop state", state, 4);
    chk("R5 nop quiet", dq_oe, 0);
    cyc(0, 1, 1, 1, 1, 0, 0);
    cyc(1, 1, 1, 1, 1, 0, 0);

    // R6 R8 refresh cycles over a wrap; R9 on the last with W low
    for (int k = 0; k < NROW + 2; k++) begin
      logic wlow;
      wlow = (k == NROW + 1);
      cyc(1, 0, 0, 1, 1, k, 0);
      chk("R6 pre refresh standby", state, 0);
      cyc(0, 0, 0, wlow ? 1'b0 : 1'b1, 1, (k * 5) % 8, 16'hFFFF);
      chk("R6 refresh state", state, 5);
      chk("R6 refresh quiet", dq_oe, 0);
      chk("R6 ptr held in cycle", rfsh_row, exp_ptr);
      chk("R9 err flag", cbr_err, wlow);
      cyc(1, 0, 0, 1, 1, 0, 0);
      exp_ptr = (exp_ptr + 1) % NROW;
      chk("R8 ptr advance wrap", rfsh_row, exp_ptr);
      cyc(1, 1, 1, 1, 1, 0, 0);
    end
    chk("R9 err holds", cbr_err, 1);

    // R3 R11 page-mode read back of every word (also shows refresh wrote nothing)
    for (int r = 0; r < NROW; r++) begin
      cyc(0, 1, 1, 1, 1, r, 0);
      if (r == 0) chk("R9 err clears", cbr_err, 0);
      for (int c = 0; c < NCOL; c++) begin
        cyc(0, 0, 0, 1, 0, c, 0);
        chk("R3 word read oe", dq_oe, 2'b11);
        chk("R3 R7 word read data", dq_out, exp_mem[r*NCOL+c]);
        cyc(0, 1, 1, 1, 0, c, 0);
      end
      cyc(1, 1, 1, 1, 1, 0, 0);
    end

    // R10 hidden refresh after a read
    cyc(0, 1, 1, 1, 1, 3, 0);
    cyc(0, 0, 0, 1, 0, 1, 0);
    chk("R3 pre hidden read", dq_out, exp_mem[3*NCOL+1]);
    cyc(1, 0, 0, 1, 0, 6, 0);
    chk("R10 hold state", state, 6);
    chk("R10 hold oe", dq_oe, 2'b11);
    chk("R10 hold data", dq_out, exp_mem[3*NCOL+1]);
    cyc(0, 0, 0, 1, 0, 6, 0);
    chk("R10 hidden state", state, 7);
    chk("R10 hidden oe", dq_oe, 2'b11);
    chk("R10 hidden data", dq_out, exp_mem[3*NCOL+1]);
    cyc(1, 0, 0, 1, 0, 0, 0);
    exp_ptr = (exp_ptr + 1) % NROW;
    chk("R10 hidden ptr", rfsh_row, exp_ptr);
    chk("R10 data after refresh", dq_out, exp_mem[3*NCOL+1]);
    cyc(1, 1, 1, 1, 1, 0, 0);
    chk("R1 end standby", state, 0);
    chk("R1 end quiet", dq_oe, 0);

    finish_run();
  end
endmodule